// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block collects the interrupt sources of a small 8-bit microcontroller core and turns them into a single interrupt request toward the CPU and a separate wake-from-sleep signal. There are three core sources. The first is an external pin that is edge-triggered with a selectable polarity. The second is a one-cycle overflow pulse from an 8-bit timer. The third is a port of pins with per-pin change detection. A vector of peripheral flag/enable pairs from other blocks is also collected.

An 8-bit control/status register holds a sticky flag and an enable for each core source, a peripheral-tier enable and a global enable. Software clears a flag by writing 0 to it. A mask register chooses which port pins take part in change detection. A read strobe marks the instant at which the CPU samples the port.

Enables work in two tiers. The peripheral term is gated by the peripheral enable, and the whole request is gated by the global enable. The wake output ignores the global enable, so the core resumes from sleep without branching to the interrupt vector when the global enable is clear.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the mask register reads 0, the edge select reads 1 (rising), and `irq_o` and `wake_o` are low. A pin held at a nonzero level through reset sets no flag.
- R2: With edge select 1, a rising edge on the external pin sets control bit 1; with edge select 0, a falling edge sets it. The opposite edge sets nothing.
- R3: A high cycle on `tmr_ovf_i` sets control bit 2 at the next clock edge.
- R4: A level change on a port pin sets control bit 0 only if that pin's mask bit is 1. Changes on pins with a mask bit of 0 set nothing.
- R5: A port change whose detection cycle coincides with a high `port_rd_i` is lost and sets no flag.
- R6: Flags in bits 0 to 2 stay set until software writes 0 to them. On a write, every control bit takes the written value. When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R7: The peripheral term (OR over `per_flag_i & per_en_i`) reaches `irq_o` and `wake_o` only while control bit 6 is 1.
- R8: `irq_o` is control bit 7 AND (core term OR gated peripheral term). The core term is the OR over each flag in bits 0 to 2 ANDed with its enable in bits 3 to 5.
- R9: `wake_o` is the core term OR the gated peripheral term, whatever the value of bit 7.
- R10: Pin inputs pass through a two-stage synchronizer. A pin change that is settled before clock edge k sets its flag at edge k+2, and each detected event lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_o | output | 8 | Control register contents |
| mask_we_i | input | 1 | Change-mask write strobe |
| mask_wdata_i | input | PORT_W | Change-mask write data |
| mask_o | output | PORT_W | Change-mask contents |
| edge_we_i | input | 1 | Edge-select write strobe |
| edge_wdata_i | input | 1 | Edge-select write data (1 = rising) |
| edge_sel_o | output | 1 | Edge-select contents |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| port_i | input | PORT_W | Port pins (asynchronous) |
| port_rd_i | input | 1 | Port read strobe |
| port_o | output | PORT_W | Synchronized port value |
| per_flag_i | input | PER_N | Peripheral flags |
| per_en_i | input | PER_N | Peripheral enables |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a timer overflow pulse is driven in the same cycle as a control write of zero, and the timer flag must end up set while the other bits clear. In the second, a port pin is toggled and the read strobe is raised exactly in the cycle its synchronized change is detected, so that no flag may appear. A read strobe placed in a different cycle must let the same change through.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CTL_W = 8;
  // control register bit positions
  localparam int B_PCF = 0;
  localparam int B_EXF = 1;
  localparam int B_TMF = 2;
  localparam int B_PCE = 3;
  localparam int B_EXE = 4;
  localparam int B_TME = 5;
  localparam int B_PIE = 6;
  localparam int B_GIE = 7;
  localparam int N_CORE = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  localparam int FILL = STAGES + 1;
  localparam int CW   = $clog2(FILL + 1);

  logic [W-1:0]  st_q [STAGES];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  // detection is held off until the chain carries real pin values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q != CW'(FILL))   cnt_q <= cnt_q + 1'b1;
  end

  assign q_o     = st_q[STAGES-1];
  assign valid_o = (cnt_q == CW'(FILL));
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic d_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign evt_o = valid_i & (rise_sel_i ? (d_i & ~prev_q) : (~d_i & prev_q));

  p_one_clock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] mask_i,
  input  logic         rd_i,
  output logic         evt_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  // reference reloads every cycle; a read in the detection cycle drops the event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= d_i;
  end

  assign diff  = (d_i ^ ref_q) & mask_i;
  assign evt_o = valid_i & ~rd_i & (|diff);

  p_masked_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (|mask_i));
  p_read_loses_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !evt_o);
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int PORT_W      = 6,
  parameter int PER_N       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_o,
  input  logic              mask_we_i,
  input  logic [PORT_W-1:0] mask_wdata_i,
  output logic [PORT_W-1:0] mask_o,
  input  logic              edge_we_i,
  input  logic              edge_wdata_i,
  output logic              edge_sel_o,
  input  logic              ext_pin_i,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              port_rd_i,
  output logic [PORT_W-1:0] port_o,
  input  logic [PER_N-1:0]  per_flag_i,
  input  logic [PER_N-1:0]  per_en_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SW = PORT_W + 1;

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [PORT_W-1:0] mask_q;
  logic              edge_sel_q;
  logic [SW-1:0]     sync_q;
  logic              sync_valid;
  logic              ext_evt, pc_evt;
  logic              core_pend, per_pend;

  irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({ext_pin_i, port_i}),
    .q_o     (sync_q),
    .valid_o (sync_valid)
  );

  irq_edge_det u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sync_valid),
    .d_i        (sync_q[SW-1]),
    .rise_sel_i (edge_sel_q),
    .evt_o      (ext_evt)
  );

  irq_port_chg #(.W(PORT_W)) u_pchg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sync_valid),
    .d_i     (sync_q[PORT_W-1:0]),
    .mask_i  (mask_q),
    .rd_i    (port_rd_i),
    .evt_o   (pc_evt)
  );

  // hardware set overrides a same-cycle software write
  always_comb begin
    ctl_d = ctl_we_i ? ctl_wdata_i : ctl_q;
    if (pc_evt)    ctl_d[B_PCF] = 1'b1;
    if (ext_evt)   ctl_d[B_EXF] = 1'b1;
    if (tmr_ovf_i) ctl_d[B_TMF] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      mask_q     <= '0;
      edge_sel_q <= 1'b1;
    end else begin
      ctl_q <= ctl_d;
      if (mask_we_i) mask_q     <= mask_wdata_i;
      if (edge_we_i) edge_sel_q <= edge_wdata_i;
    end
  end

  assign core_pend = |(ctl_q[B_TMF:B_PCF] & ctl_q[B_TME:B_PCE]);
  assign per_pend  = ctl_q[B_PIE] & (|(per_flag_i & per_en_i));
  assign irq_o     = ctl_q[B_GIE] & (core_pend | per_pend);
  assign wake_o    = core_pend | per_pend;

  assign ctl_o      = ctl_q;
  assign mask_o     = mask_q;
  assign edge_sel_o = edge_sel_q;
  assign port_o     = sync_q[PORT_W-1:0];

  p_tmr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> ctl_o[B_TMF]);
  p_ext_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_evt |=> ctl_o[B_EXF]);
  p_pc_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_evt |=> ctl_o[B_PCF]);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[B_EXF] && !ctl_we_i) |=> ctl_o[B_EXF]);
  p_gie_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[B_GIE] |-> !irq_o);
  p_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);
  p_pie_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[B_PIE] && !(|(ctl_o[B_TMF:B_PCF] & ctl_o[B_TME:B_PCE]))) |-> (!irq_o && !wake_o));
endmodule

// File: tb/irq_agg_ctrl_test.sv
module irq_agg_ctrl_test;
  localparam int PW = 6;
  localparam int PN = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl;
  logic          mask_we = 1'b0;
  logic [PW-1:0] mask_wdata = '0;
  logic [PW-1:0] mask;
  logic          edge_we = 1'b0;
  logic          edge_wdata = 1'b0;
  logic          edge_sel;
  logic          ext_pin = 1'b1;
  logic          tmr_ovf = 1'b0;
  logic [PW-1:0] port = 6'b101010;
  logic          port_rd = 1'b0;
  logic [PW-1:0] port_q;
  logic [PN-1:0] per_flag = '0;
  logic [PN-1:0] per_en = '0;
  logic          irq, wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_agg_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .mask_o(mask),
    .edge_we_i(edge_we), .edge_wdata_i(edge_wdata), .edge_sel_o(edge_sel),
    .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
    .port_i(port), .port_rd_i(port_rd), .port_o(port_q),
    .per_flag_i(per_flag), .per_en_i(per_en),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_mask(logic [PW-1:0] v);
    @(negedge clk); mask_we = 1'b1; mask_wdata = v;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic wr_edge(logic v);
    @(negedge clk); edge_we = 1'b1; edge_wdata = v;
    @(negedge clk); edge_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl, 8'h00);
    chk("R1 mask", mask, 0);
    chk("R1 edge_sel", edge_sel, 1);
    chk("R1 irq/wake", {irq, wake}, 2'b00);
    rst_n = 1'b1;
    wait_n(8);
    chk("R1 no flag from held pins", ctl, 8'h00);
  endtask

  task automatic t_timer;
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    chk("R3 timer flag", ctl[2], 1);
    wait_n(3);
    chk("R6 flag sticky", ctl, 8'h04);
    wr_ctl(8'h00);
    chk("R6 software clear", ctl, 8'h00);
  endtask

  task automatic t_ext_rise;
    @(negedge clk); ext_pin = 1'b0;
    wait_n(5);
    chk("R2 falling ignored when rising selected", ctl[1], 0);
    ext_pin = 1'b1;
    wait_n(2);
    chk("R10 not yet after two edges", ctl[1], 0);
    wait_n(1);
    chk("R10 flag at third edge", ctl[1], 1);
    wr_ctl(8'h00);
  endtask

  task automatic t_ext_fall;
    wr_edge(1'b0);
    chk("R2 edge select written", edge_sel, 0);
    ext_pin = 1'b0;
    wait_n(3);
    chk("R2 falling edge sets flag", ctl[1], 1);
    wr_ctl(8'h00);
    ext_pin = 1'b1;
    wait_n(5);
    chk("R2 rising ignored when falling selected", ctl[1], 0);
    wr_edge(1'b1);
  endtask

  task automatic t_port;
    wr_mask(6'b000011);
    port[5] = ~port[5];
    wait_n(5);
    chk("R4 unmasked pin ignored", ctl[0], 0);
    port[0] = ~port[0];
    wait_n(3);
    chk("R4 masked pin sets flag", ctl[0], 1);
    wr_ctl(8'h00);
  endtask

  task automatic t_read_race;
    port[1] = ~port[1];
    wait_n(2);
    port_rd = 1'b1;
    wait_n(1);
    port_rd = 1'b0;
    wait_n(3);
    chk("R5 change lost under read", ctl[0], 0);
    port[1] = ~port[1];
    wait_n(1);
    port_rd = 1'b1;
    wait_n(1);
    port_rd = 1'b0;
    wait_n(3);
    chk("R5 read in other cycle keeps change", ctl[0], 1);
    wr_ctl(8'h00);
  endtask

  task automatic t_set_wins;
    wr_ctl(8'h18);
    @(negedge clk); tmr_ovf = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'h00;
    @(negedge clk); tmr_ovf = 1'b0; ctl_we = 1'b0;
    chk("R6 set beats clear", ctl, 8'h04);
    wr_ctl(8'h00);
  endtask

  task automatic t_gating;
    wr_ctl(8'h24);
    chk("R9 wake without global enable", {irq, wake}, 2'b01);
    wr_ctl(8'hA4);
    chk("R8 irq with global enable", {irq, wake}, 2'b11);
    wr_ctl(8'h84);
    chk("R8 flag without its enable", {irq, wake}, 2'b00);
    wr_ctl(8'h80);
    @(negedge clk); per_flag = 8'h08; per_en = 8'h08;
    @(negedge clk);
    chk("R7 peripheral blocked by tier enable", {irq, wake}, 2'b00);
    wr_ctl(8'hC0);
    chk("R7 peripheral passes tier enable", {irq, wake}, 2'b11);
    wr_ctl(8'h40);
    chk("R9 peripheral wake without global", {irq, wake}, 2'b01);
    @(negedge clk); per_en = 8'h04;
    @(negedge clk);
    chk("R7 disabled peripheral flag", {irq, wake}, 2'b00);
    per_flag = '0; per_en = '0;
    wr_ctl(8'h00);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_timer();
    t_ext_rise();
    t_ext_fall();
    t_port();
    t_read_race();
    t_set_wins();
    t_gating();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule